// File: doc/BRIEF.md
# Serial Receiver with Line Status and Receive Queue

This block takes an asynchronous serial input line, brings it into the clock domain, and turns each character frame into a byte. It uses a one-cycle enable pulse at sixteen times the bit rate, which a separate rate generator supplies. A character can be 5 to 8 data bits long, may carry a parity bit checked in one of four modes, and ends with a stop bit. Each received character goes into a 16-entry queue that is read oldest first. The character's parity, framing and break flags are stored with it in the same queue entry.

An 8-bit status word describes the character at the head of the queue. It also shows whether any stored character is damaged and whether a character was lost because the queue was full. An interrupt output goes high while the queue fill is at or above a level chosen by a 2-bit code. A clear strobe empties the queue. A status-read strobe tells the block that software has consumed the status word.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset, status reads 0x00, irq_o is 0 and rd_data is 0x00. Status bits 5 and 6 always read 0.
- R2: A low level on rx_i counts as a start bit only if it is still low at the middle of the start bit, 8 ticks after detection. A shorter low pulse produces no character.
- R3: Data bits are received least significant first, with each bit sampled at its midpoint. Characters leave the queue in arrival order. rd_data shows the oldest entry, and a pulse on rd_en removes it. rd_en on an empty queue has no effect.
- R4: cfg_wlen selects the data length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Unused upper bits of rd_data read 0.
- R5: When cfg_par_en is 1, a parity bit follows the data. cfg_par_sel selects the check: 00 odd, 01 even, 10 parity bit must be 1, 11 parity bit must be 0. A mismatch sets status bit 2 for that character.
- R6: A stop bit sampled as 0 sets status bit 3 for that character.
- R7: If every sampled position of a frame, including the stop position, is 0, the character is stored as 0x00 with status bits 4 and 3 set. No new start bit is accepted until rx_i has returned to 1.
- R8: Error flags belong to their own queue entry. Status bits 2 to 4 describe the head entry only. Status bit 7 is 1 while any stored entry carries an error.
- R9: If a character completes while the queue holds 16 entries, that character is discarded and status bit 1 is set. Bit 1 clears on the clock edge where stat_rd is 1.
- R10: irq_o is 1 while the fill level is at least the trigger level. cfg_trig selects the level: 00 is 1, 01 is 4, 10 is 8 and 11 is 14.
- R11: A pulse on fifo_clr empties the queue, so status bits 0 and 7 read 0 afterwards.
- R12: Status bit 0 is 1 exactly while the queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_sel | input | 2 | Parity check mode |
| cfg_trig | input | 2 | Interrupt trigger level code |
| fifo_clr | input | 1 | Empty the receive queue |
| rd_en | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status word consumed; clears overrun |
| rd_data | output | 8 | Head entry data, 0 when empty |
| status | output | 8 | Line status word |
| irq_o | output | 1 | Fill level at or above trigger |

## Verification
The assertions assume the format inputs stay constant during a frame. They also assume rd_en, fifo_clr and stat_rd are not pulsed in the same cycle a character completes, and that tick16 is spaced at least a few clocks apart so the synchronizer settles between ticks. The bench changes the configuration only while the line is idle and issues its strobes between frames. It uses a tick every four clocks and drives each bit for 64 clocks, aligned to the clock but not to the tick. The random phase is drawn from a fixed seed and sends characters in varying lengths and parity modes, some with a corrupted parity bit. The directed cases cover the start-bit glitch, break, framing error, a full queue and each trigger level.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: data characters are at most 8 bits wide.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
    } rx_state_t;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_char_t;

    // Interrupt fill level chosen by the 2-bit trigger code.
    function automatic logic [7:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Module: multi-flop synchronizer for the serial input.
// Assumes: the input idles high, so the flops reset to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame engine. Validates the start bit, samples data, parity and stop
// at bit midpoints on the 16x tick, and emits one character with its flags.
// Assumes: format inputs are stable for the length of a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       push,
    output rx_char_t   char_o
);
    rx_state_t  state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sr;
    logic       par_bit;
    logic       all_zero;
    logic [2:0] last_idx;
    logic       par_bad;
    logic       mid_bit;

    assign last_idx = 3'd4 + {1'b0, wlen};
    assign mid_bit  = tick && (tcnt == 4'd15);

    // Compare the received parity bit with the selected rule.
    always_comb begin
        case (par_sel)
            2'b00:   par_bad = ~((^sr) ^ par_bit);
            2'b01:   par_bad = (^sr) ^ par_bit;
            2'b10:   par_bad = ~par_bit;
            default: par_bad = par_bit;
        endcase
    end

    // Step through the frame and build the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            sr       <= '0;
            par_bit  <= 1'b0;
            all_zero <= 1'b0;
            push     <= 1'b0;
            char_o   <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !rx) begin
                        state <= ST_START;
                        tcnt  <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (tcnt == 4'd7) begin
                            tcnt     <= '0;
                            bidx     <= '0;
                            sr       <= '0;
                            all_zero <= 1'b1;
                            state    <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid_bit) begin
                        sr[bidx] <= rx;
                        all_zero <= all_zero & ~rx;
                        tcnt     <= '0;
                        if (bidx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                        else                  bidx  <= bidx + 3'd1;
                    end else if (tick) begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                ST_PAR: begin
                    if (mid_bit) begin
                        par_bit  <= rx;
                        all_zero <= all_zero & ~rx;
                        tcnt     <= '0;
                        state    <= ST_STOP;
                    end else if (tick) begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                ST_STOP: begin
                    if (mid_bit) begin
                        push        <= 1'b1;
                        char_o.data <= sr;
                        char_o.pe   <= par_en & par_bad;
                        char_o.fe   <= ~rx;
                        char_o.brk  <= all_zero & ~rx;
                        tcnt        <= '0;
                        state       <= rx ? ST_IDLE : ST_WAIT_HI;
                    end else if (tick) begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                ST_WAIT_HI: begin
                    if (rx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A start bit high again at its midpoint must abandon the frame.
    p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && tcnt == 4'd7 && rx) |=> (state == ST_IDLE));

    // A break character must also carry the framing flag and zero data.
    p_break_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && char_o.brk) |-> (char_o.fe && char_o.data == 8'h00));

    // 5-bit words leave the top three bits zero.
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wlen == 2'b00) |-> (char_o.data[7:5] == 3'b000));

    // While waiting for the line to rise, no new frame starts.
    p_wait_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HI && !rx) |=> (state == ST_WAIT_HI));
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: receive queue holding each character with its error flags,
// plus a running count of stored entries that carry an error.
// Assumes: DEPTH is a power of two; a push into a full queue is dropped.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  rx_char_t      din,
    input  logic          pop,
    output rx_char_t      dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          err_any,
    output logic          ovf
);
    rx_char_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] errcnt;
    logic          full, do_push, do_pop, in_err, out_err;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign ovf     = push && full && !clr;
    assign dout    = mem[rp];
    assign in_err  = din.pe | din.fe | din.brk;
    assign out_err = dout.pe | dout.fe | dout.brk;
    assign err_any = (errcnt != '0);

    // Write the arriving character into its slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Track pointers, fill level and the count of erroneous entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp     <= '0;
            rp     <= '0;
            count  <= '0;
            errcnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count  <= count + CW'(do_push) - CW'(do_pop);
            errcnt <= errcnt + CW'(do_push & in_err) - CW'(do_pop & out_err);
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // A push into a full queue must not change the fill.
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));

    p_clear_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && errcnt == '0));

    p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

    p_errcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        errcnt <= count);
endmodule

// File: rtl/uart_rx_lsr.sv
// Module: top of the serial receiver. Joins synchronizer, frame engine and
// queue, and forms the status word, overrun flag and fill-level interrupt.
// Assumes: tick16 pulses for one clock at 16x the bit rate.
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_i,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_sel,
    input  logic [1:0] cfg_trig,
    input  logic       fifo_clr,
    input  logic       rd_en,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       irq_o
);
    logic          rx_s, push, empty, err_any, ovf, ovr_flag;
    rx_char_t      new_char, head;
    logic [CW-1:0] count;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_i), .dout(rx_s)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .wlen(cfg_wlen), .par_en(cfg_par_en), .par_sel(cfg_par_sel),
        .push(push), .char_o(new_char)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .din(new_char),
        .pop(rd_en), .dout(head), .count(count), .empty(empty),
        .err_any(err_any), .ovf(ovf)
    );

    // Hold the overrun flag until the status word is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (ovf)     ovr_flag <= 1'b1;
        else if (stat_rd) ovr_flag <= 1'b0;
    end

    // Assemble the status word and the head data from the queue head.
    always_comb begin
        rd_data = empty ? 8'h00 : head.data;
        status  = {err_any, 2'b00,
                   ~empty & head.brk, ~empty & head.fe, ~empty & head.pe,
                   ovr_flag, ~empty};
    end

    // Raise the interrupt at or above the selected fill.
    always_comb irq_o = (32'(count) >= 32'(trig_level(cfg_trig)));

    p_irq_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status[0]);

    p_err_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] | status[3] | status[4]) |-> status[7]);

    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovf) |=> !status[1]);

    p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> status[1]);

    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00);
endmodule

// File: tb/test_uart_rx_lsr.sv
module test_uart_rx_lsr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_i = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_sel = 2'b00;
    logic [1:0] cfg_trig = 2'b00;
    logic       fifo_clr = 1'b0;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data, status;
    logic       irq_o;
    int         n_chk = 0;
    int         n_err = 0;
    logic [1:0] tdiv = '0;
    bit         done = 0;

    uart_rx_lsr i_uart_rx_lsr (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_i(rx_i),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
        .cfg_trig(cfg_trig), .fifo_clr(fifo_clr), .rd_en(rd_en), .stat_rd(stat_rd),
        .rd_data(rd_data), .status(status), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] wl);
        return 8'hFF >> (2'd3 - wl);
    endfunction

    function automatic logic par_of(input logic [7:0] d);
        logic x;
        x = ^(d & mask_of(cfg_wlen));
        case (cfg_par_sel)
            2'b00:   return ~x;
            2'b01:   return x;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge clk) rx_i = b;
        repeat (63) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic bad_par, input logic stop_v);
        int nb;
        nb = int'(cfg_wlen) + 5;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (cfg_par_en) drive_bit(par_of(d) ^ bad_par);
        drive_bit(stop_v);
        @(negedge clk) rx_i = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] ed, input logic [7:0] es);
        @(negedge clk);
        chk(req, {24'h0, rd_data}, {24'h0, ed});
        chk(req, {24'h0, status}, {24'h0, es});
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       bp;
        logic [7:0] es;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {24'h0, status}, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 data", {24'h0, rd_data}, 32'h0);

        // R2 short low glitch is not a start bit
        @(negedge clk) rx_i = 1'b0;
        repeat (20) @(negedge clk);
        rx_i = 1'b1;
        repeat (1200) @(negedge clk);
        chk("R2 glitch ignored", {24'h0, status}, 32'h0);

        // R3 8-bit order, R12 ready flag, empty pop ignored
        send_char(8'hA5, 1'b0, 1'b1);
        send_char(8'h3C, 1'b0, 1'b1);
        chk("R12 ready", {31'h0, status[0]}, 32'h1);
        pop_expect("R3 first", 8'hA5, 8'h01);
        pop_expect("R3 second", 8'h3C, 8'h01);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        send_char(8'h81, 1'b0, 1'b1);
        pop_expect("R3 pop empty ignored", 8'h81, 8'h01);
        chk("R12 empty", {24'h0, status}, 32'h0);

        // R4 short words padded with zeros
        for (int w = 0; w < 3; w++) begin
            cfg_wlen = 2'(w);
            send_char(8'hFF, 1'b0, 1'b1);
            pop_expect("R4 pad", mask_of(2'(w)), 8'h01);
        end
        cfg_wlen = 2'b11;

        // R5 parity modes, good and bad
        cfg_par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_par_sel = 2'(m);
            send_char(8'h6B, 1'b0, 1'b1);
            pop_expect("R5 good parity", 8'h6B, 8'h01);
            send_char(8'h6B, 1'b1, 1'b1);
            pop_expect("R5 bad parity", 8'h6B, 8'h85);
        end
        cfg_par_en = 1'b0;

        // R6 framing error
        send_char(8'h55, 1'b0, 1'b0);
        pop_expect("R6 framing", 8'h55, 8'h89);

        // R7 break held longer than a frame, then a normal character
        @(negedge clk) rx_i = 1'b0;
        repeat (64 * 13) @(negedge clk);
        rx_i = 1'b1;
        repeat (64) @(negedge clk);
        chk("R7 break once", {27'h0, i_uart_rx_lsr.status[0], 4'h0}, 32'h10);
        pop_expect("R7 break", 8'h00, 8'h99);
        send_char(8'h42, 1'b0, 1'b1);
        pop_expect("R7 after break", 8'h42, 8'h01);

        // R8 flags belong to their own entry
        cfg_par_en = 1'b1;
        cfg_par_sel = 2'b01;
        send_char(8'h11, 1'b0, 1'b1);
        send_char(8'h22, 1'b1, 1'b1);
        pop_expect("R8 clean head, error behind", 8'h11, 8'h81);
        pop_expect("R8 error head", 8'h22, 8'h85);
        chk("R8 summary cleared", {24'h0, status}, 32'h0);
        cfg_par_en = 1'b0;

        // R10 trigger levels 1 and 4
        cfg_trig = 2'b00;
        send_char(8'h01, 1'b0, 1'b1);
        chk("R10 level1", {31'h0, irq_o}, 32'h1);
        cfg_trig = 2'b01;
        @(negedge clk);
        chk("R10 level4 below", {31'h0, irq_o}, 32'h0);
        for (int i = 0; i < 3; i++) send_char(8'h02 + 8'(i), 1'b0, 1'b1);
        chk("R10 level4 reached", {31'h0, irq_o}, 32'h1);
        cfg_trig = 2'b10;
        @(negedge clk);
        chk("R10 level8 below", {31'h0, irq_o}, 32'h0);
        pulse_clr();
        @(negedge clk);
        // R11 clear empties queue
        chk("R11 cleared", {24'h0, status}, 32'h0);

        // R9 overrun with R10 level 14
        cfg_trig = 2'b11;
        for (int i = 0; i < 13; i++) send_char(8'h40 + 8'(i), 1'b0, 1'b1);
        chk("R10 level14 below", {31'h0, irq_o}, 32'h0);
        send_char(8'h4D, 1'b0, 1'b1);
        chk("R10 level14 reached", {31'h0, irq_o}, 32'h1);
        send_char(8'h4E, 1'b0, 1'b1);
        send_char(8'h4F, 1'b0, 1'b1);
        chk("R9 full no overrun", {31'h0, status[1]}, 32'h0);
        send_char(8'hEE, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 overrun set", {24'h0, status}, 32'h03);
        stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        chk("R9 overrun cleared", {24'h0, status}, 32'h01);
        for (int i = 0; i < 16; i++) pop_expect("R9 kept order", 8'h40 + 8'(i), 8'h01);
        chk("R9 extra discarded", {24'h0, status}, 32'h0);

        // R11 clear with error entries present
        cfg_par_en = 1'b1;
        send_char(8'h77, 1'b1, 1'b1);
        send_char(8'h78, 1'b0, 1'b1);
        pulse_clr();
        @(negedge clk);
        chk("R11 cleared with errors", {24'h0, status}, 32'h0);

        // R3 R4 R5 random formats
        for (int k = 0; k < 40; k++) begin
            cfg_wlen    = 2'($urandom_range(0, 3));
            cfg_par_en  = 1'($urandom_range(0, 1));
            cfg_par_sel = 2'($urandom_range(0, 3));
            d  = 8'($urandom);
            bp = 1'($urandom_range(0, 3) == 0);
            send_char(d, bp, 1'b1);
            es = (bp && cfg_par_en) ? 8'h85 : 8'h01;
            pop_expect("R5 random", d & mask_of(cfg_wlen), es);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule